// File: doc/BRIEF.md
# Booth Signed Sequential Multiplier

This block multiplies two signed two's-complement operands of a configurable width using Booth's recoding, one multiplier bit per clock. A one-cycle `start` pulse while the block is idle captures both operands. The block then runs for exactly `WIDTH` clocks. In each clock it looks at the lowest multiplier bit together with a trailing history bit. From that pair it adds the multiplicand to the upper half of the product register, subtracts it, or leaves it as it is. The whole product register then shifts right by one place, keeping the sign.

Once the last step is done, `busy` drops and `done` pulses for one cycle. The full double-width signed product stays on `product` until the next accepted `start`. The upper-half arithmetic is one bit wider than the operands. This lets even the most negative multiplicand be subtracted without wrapping.

Top module: `booth_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` sampled high while `busy` is 0 loads the operands. `busy` is 1 in the following cycle and stays 1 for exactly `WIDTH` cycles.
- R3: `done` is 1 for exactly one cycle, in the cycle right after `busy` falls, and is never 1 together with `busy`.
- R4: When `done` is 1, `product` (2×`WIDTH` bits, two's complement) equals the signed product of the captured multiplicand and multiplier, for every pair of `WIDTH`-bit signed operands.
- R5: The most negative operand value (bit pattern 1 followed by zeros) gives the correct product in either position. For example, −8 × −8 = +64 and −8 × 7 = −56 at `WIDTH`=4.
- R6: A `start` that arrives while `busy` is 1 is ignored. Neither the timing nor the product of the running operation changes.
- R7: While idle and with `start` low, `product` holds its value, whatever the operand inputs do.
- R8: A `start` raised in the same cycle that `done` is 1 is accepted. A new operation begins, with `busy` at 1 in the next cycle.
- R9: Negative operands follow signed rules, not unsigned ones. 0111 × 0011 gives 0001 0101 (+21), and 1011 × 1101 gives 0000 1111 (+15).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin a multiplication; honoured only when idle |
| multiplicand | input | WIDTH | Signed multiplicand, captured on an accepted start |
| multiplier | input | WIDTH | Signed multiplier, captured on an accepted start |
| busy | output | 1 | High while the iterations run |
| done | output | 1 | One-cycle pulse when the product becomes valid |
| product | output | 2*WIDTH | Signed product, held until the next accepted start |

## Verification
Completion and a new start can fall in the same cycle. The end-of-run pulse and the capture of fresh operands then compete for the product register and the control state. The bench provokes this by raising `start` with new operands exactly in the cycle where `done` is seen high. It then judges that `done` drops, `busy` rises the next cycle, and the second result is correct `WIDTH` cycles later. A start that lands in the middle of a run is also pushed in with different operands. It must leave the timing and the running product untouched.

// File: rtl/booth_pkg.sv
package booth_pkg;
  // Strobes passed from the sequencer to the datapath
  typedef struct packed {
    logic load;  // capture operands, clear upper half and history bit
    logic step;  // one recode-and-shift iteration
  } boothStrobe_t;
endpackage

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int WIDTH = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  output booth_pkg::boothStrobe_t strobe,
  output logic                    busy,
  output logic                    done
);
  localparam int CW = $clog2(WIDTH + 1);

  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_t;

  ctrlState_t state;
  logic [CW-1:0] iterLeft;
  logic lastIter;

  assign lastIter    = (iterLeft == CW'(1));
  assign strobe.load = start && (state == ST_IDLE);
  assign strobe.step = (state == ST_RUN);
  assign busy        = (state == ST_RUN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      iterLeft <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_RUN;
            iterLeft <= CW'(WIDTH);
          end
        end
        ST_RUN: begin
          iterLeft <= iterLeft - CW'(1);
          if (lastIter) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy) else $error("idle start not accepted"); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done longer than one cycle"); // R3
  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy)) else $error("done overlaps busy"); // R3
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done) else $error("busy fell without done"); // R3
  AST_RUN_NOT_RESTARTED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !lastIter) |=> (busy && $stable(strobe.load))) else $error("busy start disturbed run"); // R6
endmodule

// File: rtl/booth_dp.sv
module booth_dp #(
  parameter int WIDTH = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  booth_pkg::boothStrobe_t strobe,
  input  logic [WIDTH-1:0]        multiplicand,
  input  logic [WIDTH-1:0]        multiplier,
  output logic [2*WIDTH-1:0]      product
);
  localparam int EW = WIDTH + 1;  // guard bit keeps A +/- M from wrapping

  logic [WIDTH-1:0] accHi;
  logic [WIDTH-1:0] mulLo;
  logic             histBit;
  logic [WIDTH-1:0] mcandReg;
  logic [EW-1:0]    accExt;
  logic [EW-1:0]    mcandExt;
  logic [EW-1:0]    sumExt;

  assign accExt   = {accHi[WIDTH-1], accHi};
  assign mcandExt = {mcandReg[WIDTH-1], mcandReg};

  // Recode on the low multiplier bit and the history bit
  always_comb begin
    unique case ({mulLo[0], histBit})
      2'b10:   sumExt = accExt - mcandExt;
      2'b01:   sumExt = accExt + mcandExt;
      default: sumExt = accExt;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accHi    <= '0;
      mulLo    <= '0;
      histBit  <= 1'b0;
      mcandReg <= '0;
    end else if (strobe.load) begin
      accHi    <= '0;
      mulLo    <= multiplier;
      histBit  <= 1'b0;
      mcandReg <= multiplicand;
    end else if (strobe.step) begin
      // arithmetic right shift of {sum, Q, Q-1}; sum's guard bit is the sign
      accHi   <= sumExt[EW-1:1];
      mulLo   <= {sumExt[0], mulLo[WIDTH-1:1]};
      histBit <= mulLo[0];
    end
  end

  assign product = {accHi, mulLo};

  AST_LOAD_STATE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (product == {{WIDTH{1'b0}}, $past(multiplier)})) else $error("load state wrong"); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.step) |=> $stable(product)) else $error("product moved while idle"); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> (accHi[WIDTH-1] == $past(sumExt[EW-1]))) else $error("sign lost in shift"); // R5
endmodule

// File: rtl/booth_mul.sv
module booth_mul #(
  parameter int WIDTH = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [WIDTH-1:0]     multiplicand,
  input  logic [WIDTH-1:0]     multiplier,
  output logic                 busy,
  output logic                 done,
  output logic [2*WIDTH-1:0]   product
);
  booth_pkg::boothStrobe_t strobe;

  booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  booth_dp #(.WIDTH(WIDTH)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .product      (product)
  );
endmodule

// File: tb/booth_mul_tb.sv
module booth_mul_tb;
  localparam int W = 4;
  localparam int PW = 2 * W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] mcand = '0;
  logic [W-1:0] mplier = '0;
  logic busy, done;
  logic [PW-1:0] product;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  booth_mul #(.WIDTH(W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start),
    .multiplicand(mcand), .multiplier(mplier),
    .busy(busy), .done(done), .product(product)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int refProd(input logic [W-1:0] a, input logic [W-1:0] b);
    int sa, sb;
    sa = $signed(a);
    sb = $signed(b);
    return sa * sb;
  endfunction

  // Launch at a negedge; returns at the negedge where done should be high
  task automatic runOp(input logic [W-1:0] a, input logic [W-1:0] b,
                       input bit midStart, output bit timingOk);
    timingOk = 1;
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (!busy || done) timingOk = 0;
      if (midStart && i == 1) begin
        start = 1'b1; mcand = ~a; mplier = ~b;
      end
      @(negedge clk);
      start = 1'b0;
    end
    if (busy || !done) timingOk = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    bit tOk;
    int exp;
    logic [PW-1:0] held;
    repeat (2) @(negedge clk);
    check(!busy && !done && product == '0, "R1", "reset state", product, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R9 textbook cases
    runOp(4'b0111, 4'b0011, 0, tOk);
    check(product == 8'b0001_0101, "R9", "7x3", product, 21);
    runOp(4'b1011, 4'b1101, 0, tOk);
    check(product == 8'b0000_1111, "R9", "-5x-3", product, 15);

    // R5 most negative
    runOp(4'b1000, 4'b1000, 0, tOk);
    check($signed(product) == 64, "R5", "-8x-8", $signed(product), 64);
    runOp(4'b1000, 4'b0111, 0, tOk);
    check($signed(product) == -56, "R5", "-8x7", $signed(product), -56);
    runOp(4'b0111, 4'b1000, 0, tOk);
    check($signed(product) == -56, "R5", "7x-8", $signed(product), -56);

    // R4 / R2 / R3 exhaustive sweep
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        runOp(W'(a), W'(b), 0, tOk);
        exp = refProd(W'(a), W'(b));
        check($signed(product) == exp, "R4", "sweep product", $signed(product), exp);
        check(tOk, "R2", "busy window / done pulse", tOk, 1);
        @(negedge clk);
        check(!done, "R3", "done single cycle", done, 0);
      end
    end

    // R7 hold while idle with moving operands
    runOp(4'b0101, 4'b1110, 0, tOk);
    held = product;
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      mcand = W'(k * 3); mplier = W'(k + 5);
      @(negedge clk);
    end
    check(product == held && !busy && !done, "R7", "idle hold", product, held);

    // R6 start during run ignored
    runOp(4'b0110, 4'b1101, 1, tOk);
    check(tOk, "R6", "timing with mid-run start", tOk, 1);
    check($signed(product) == -18, "R6", "product with mid-run start", $signed(product), -18);
    @(negedge clk);
    check(!busy, "R6", "no restart after run", busy, 0);

    // R8 start in the done cycle
    runOp(4'b0011, 4'b0101, 0, tOk);
    check($signed(product) == 15, "R8", "first result", $signed(product), 15);
    runOp(4'b1001, 4'b0110, 0, tOk);  // started while done was high
    check(tOk, "R8", "back-to-back timing", tOk, 1);
    check($signed(product) == -42, "R8", "second result", $signed(product), -42);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule